// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is a parameterised register, eight bits wide by default. A two-bit mode select chooses one of four actions on each rising clock edge: keep the contents, move every bit one place toward the high end, move every bit one place toward the low end, or capture a parallel word. Each shift direction has its own serial input, which feeds the vacated end. An active-low reset clears the register at once, without waiting for a clock edge.

The parallel port is modelled for a bidirectional bus. It has a data-in word, a data-out word that always shows the register contents, and a single drive-enable that tells an outside pad ring when to put the data-out word on the bus. The drive-enable is low when either of two active-low output enables is high. It is also low whenever load mode is selected, so the register can take the bus value in without any separate enable sequence. The lowest and highest bits also come out on two dedicated serial taps. These taps have no gating, so several registers can be chained through their taps into one longer word.

Top module: `univ_shift_reg`

## Requirements
- R1: While `rst_n` is low, every register bit is 0. The reset takes effect as soon as `rst_n` falls, with no clock edge needed, and it overrides both the mode select and the clock.
- R2: With `mode` = 2'b00, a rising edge leaves the contents unchanged, whatever the values on the serial inputs and on `par_in`.
- R3: With `mode` = 2'b01, a rising edge moves bit n to bit n+1 and loads `ser_in_up` into bit 0.
- R4: With `mode` = 2'b10, a rising edge moves bit n to bit n-1 and loads `ser_in_down` into bit WIDTH-1.
- R5: With `mode` = 2'b11, a rising edge copies `par_in` into the register.
- R6: `par_drive` is 0 whenever `oe_a_n` or `oe_b_n` is 1.
- R7: `par_drive` is 0 whenever `mode` = 2'b11. In every other mode it is 1 when both output enables are 0. It follows the current inputs combinationally.
- R8: Holding, shifting, loading and reset work the same whether `par_drive` is 0 or 1. `par_out` shows the register contents in either case.
- R9: `tap_lo` always equals register bit 0 and `tap_hi` always equals bit WIDTH-1, whatever the output enables are. Two instances chained through their taps behave as one register of twice the width in both shift directions.
- R10: Apart from reset, the contents change only on a rising clock edge. A change of mode or data between edges leaves `par_out` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_in_up | input | 1 | Serial bit that enters bit 0 on an upward shift |
| ser_in_down | input | 1 | Serial bit that enters bit WIDTH-1 on a downward shift |
| oe_a_n | input | 1 | Output enable, active low |
| oe_b_n | input | 1 | Output enable, active low |
| par_in | input | WIDTH | Parallel word taken from the bus in load mode |
| par_out | output | WIDTH | Register contents, to be placed on the bus |
| par_drive | output | 1 | High when the bus drivers should be on |
| tap_lo | output | 1 | Ungated copy of bit 0 |
| tap_hi | output | 1 | Ungated copy of bit WIDTH-1 |

## Verification
The bench chains two instances through their taps and compares them with a 16-bit model for long shifts in each direction. A design that swapped the ends of the taps, or fed a serial input into the wrong end, would break the carry across the chain boundary. It loads all 256 words with the output enables toggling, and it sweeps every combination of mode and output enables against the drive-enable. This catches a design that keeps driving during a load, or that stops loading while its drivers are off. It also pulls reset between clock edges, holding load mode and a full word at the port, and changes the mode with no edge in between. A design with a synchronous clear, or one that updates on the wrong event, shows a non-zero or changed word at those sample points.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Mode select encoding; the values are part of the block's interface.
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  shift_mode_e        mode,
    input  logic               ser_up,
    input  logic               ser_down,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   par_in,
    output logic [WIDTH-1:0]   nxt
);
    localparam int MSB = WIDTH - 1;

    // One four-way selector per bit; the end bits take the serial inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_low_end
            assign from_below = ser_up;
        end else begin : g_low_mid
            assign from_below = cur[i-1];
        end

        if (i == MSB) begin : g_high_end
            assign from_above = ser_down;
        end else begin : g_high_mid
            assign from_above = cur[i+1];
        end

        assign nxt[i] = (mode == MODE_LOAD) ? par_in[i]  :
                        (mode == MODE_UP)   ? from_below :
                        (mode == MODE_DOWN) ? from_above :
                                              cur[i];
    end

endmodule

// File: rtl/usr_port_ctrl.sv
module usr_port_ctrl
    import usr_pkg::*;
(
    input  shift_mode_e mode,
    input  logic        oe_a_n,
    input  logic        oe_b_n,
    output logic        drive
);
    logic enables_on;
    logic port_is_input;

    assign enables_on    = ~(oe_a_n | oe_b_n);
    assign port_is_input = (mode == MODE_LOAD);
    assign drive         = enables_on & ~port_is_input;

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_up,
    input  logic             ser_in_down,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             par_drive,
    output logic             tap_lo,
    output logic             tap_hi
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } reg_state_t;

    reg_state_t       st_d;
    reg_state_t       st_q;
    shift_mode_e      mode_sel;
    logic [WIDTH-1:0] nxt_bits;

    assign mode_sel = shift_mode_e'(mode);

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .mode     (mode_sel),
        .ser_up   (ser_in_up),
        .ser_down (ser_in_down),
        .cur      (st_q.bits),
        .par_in   (par_in),
        .nxt      (nxt_bits)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_out = st_q.bits;
    assign tap_lo  = st_q.bits[0];
    assign tap_hi  = st_q.bits[MSB];

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (par_out == '0)); // R1
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (par_out == $past(par_out))); // R2
    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (par_out == {$past(par_out[MSB-1:0]), $past(ser_in_up)})); // R3
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (par_out == {$past(ser_in_down), $past(par_out[MSB:1])})); // R4
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (par_out == $past(par_in))); // R5

    usr_port_ctrl u_port (
        .mode   (mode_sel),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .drive  (par_drive)
    );

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !par_drive); // R6
    AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> !par_drive); // R7
    AST_TAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        tap_lo == par_out[0]); // R9
    AST_TAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        tap_hi == par_out[MSB]); // R9

endmodule

// File: tb/sim_univ_shift_reg.sv
`timescale 1ns/1ps
module sim_univ_shift_reg;
    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] mode;
    logic ser_up_ext, ser_down_ext;
    logic oe_a_n, oe_b_n;
    logic [7:0] pin0, pin1, pout0, pout1;
    logic drv0, drv1;
    logic lo0, hi0, lo1, hi1;
    logic [15:0] model;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // u0 holds bits 7:0 of the chained word, u1 holds bits 15:8.
    univ_shift_reg #(.WIDTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ser_in_up(ser_up_ext), .ser_in_down(lo1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .par_in(pin0),
        .par_out(pout0), .par_drive(drv0), .tap_lo(lo0), .tap_hi(hi0)
    );
    univ_shift_reg #(.WIDTH(8)) u1 (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ser_in_up(hi0), .ser_in_down(ser_down_ext),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .par_in(pin1),
        .par_out(pout1), .par_drive(drv1), .tap_lo(lo1), .tap_hi(hi1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        chk("R9 taps", {28'd0, hi1, lo1, hi0, lo0},
            {28'd0, pout1[7], pout1[0], pout0[7], pout0[0]});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b1; mode = 2'b00; ser_up_ext = 0; ser_down_ext = 0;
        oe_a_n = 0; oe_b_n = 0; pin0 = 8'hFF; pin1 = 8'hFF;
        #3 rst_n = 1'b0;
        #1 chk("R1 async clear before any edge", {16'd0, pout1, pout0}, 32'd0);
        mode = 2'b11;
        tick();
        chk("R1 reset overrides load", {16'd0, pout1, pout0}, 32'd0);
        rst_n = 1'b1;
        mode = 2'b00;

        // Drive-enable sweep over all modes and enables (R6, R7).
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 4; e++) begin
                mode = m[1:0]; oe_a_n = e[0]; oe_b_n = e[1];
                #1;
                chk((e != 0) ? "R6 drive gated by enables" : "R7 drive off in load",
                    {30'd0, drv1, drv0},
                    {30'd0, {2{(e == 0) && (m != 3)}}});
            end
        end
        mode = 2'b00; oe_a_n = 0; oe_b_n = 0;

        // Exhaustive load with enables toggling (R5, R8).
        for (int v = 0; v < 256; v++) begin
            mode = 2'b11; pin0 = v[7:0]; pin1 = ~v[7:0];
            oe_a_n = v[0]; oe_b_n = v[1];
            tick();
            model = {~v[7:0], v[7:0]};
            chk((v[1:0] != 0) ? "R8 load with drivers off" : "R5 load",
                {16'd0, pout1, pout0}, {16'd0, model});
        end

        // Hold with noisy inputs (R2).
        for (int k = 0; k < 10; k++) begin
            mode = 2'b00; ser_up_ext = k[0]; ser_down_ext = ~k[1];
            pin0 = 8'(k * 37); pin1 = 8'(k * 91);
            tick();
            chk("R2 hold", {16'd0, pout1, pout0}, {16'd0, model});
        end

        // No change between edges (R10).
        mode = 2'b11; pin0 = ~model[7:0]; pin1 = ~model[15:8];
        #3 chk("R10 no change without edge", {16'd0, pout1, pout0}, {16'd0, model});
        mode = 2'b00;

        // Chained upward shift (R3).
        for (int k = 0; k < 40; k++) begin
            mode = 2'b01;
            ser_up_ext = k[0] ^ k[2] ^ k[3];
            ser_down_ext = ~ser_up_ext;
            oe_a_n = k[1];
            tick();
            model = {model[14:0], k[0] ^ k[2] ^ k[3]};
            chk(k[1] ? "R8 shift up drivers off" : "R3 shift up",
                {16'd0, pout1, pout0}, {16'd0, model});
        end

        // Chained downward shift (R4).
        for (int k = 0; k < 40; k++) begin
            mode = 2'b10;
            ser_down_ext = k[1] ^ k[4] ^ k[0];
            ser_up_ext = k[2];
            oe_b_n = k[2];
            tick();
            model = {k[1] ^ k[4] ^ k[0], model[15:1]};
            chk(k[2] ? "R8 shift down drivers off" : "R4 shift down",
                {16'd0, pout1, pout0}, {16'd0, model});
        end

        // Mixed modes.
        for (int k = 0; k < 64; k++) begin
            mode = k[1:0] ^ k[3:2];
            ser_up_ext = k[3]; ser_down_ext = k[0];
            pin0 = 8'(k * 29 + 3); pin1 = 8'(k * 53 + 7);
            oe_a_n = k[4]; oe_b_n = 0;
            tick();
            case (k[1:0] ^ k[3:2])
                2'b00: ;
                2'b01: model = {model[14:0], k[3]};
                2'b10: model = {k[0], model[15:1]};
                default: model = {8'(k * 53 + 7), 8'(k * 29 + 3)};
            endcase
            chk("R2 R3 R4 R5 mixed", {16'd0, pout1, pout0}, {16'd0, model});
        end

        // Reset between edges (R1).
        mode = 2'b11; pin0 = 8'hA5; pin1 = 8'h5A;
        rst_n = 1'b0;
        #1 chk("R1 mid-cycle clear", {16'd0, pout1, pout0}, 32'd0);
        tick();
        chk("R1 held across edge", {16'd0, pout1, pout0}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R5 load after reset", {16'd0, pout1, pout0}, 32'h00005AA5);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule